// File: doc/BRIEF.md
# Physical Memory Target Router

This block sits beside a processor's load/store path and decides, for each memory access, whether it should be sent to system RAM or to the memory-mapped I/O fabric. The decision is combinational from the request address, the access direction and a small set of model-specific registers. A cacheable hint comes out alongside it.

Software programs the block through a model-specific register port with a 32-bit index and 64-bit data. The port holds a top-of-memory bound, a system-configuration word and eleven fixed-range memory-type registers. Each memory-type register holds eight one-byte attribute fields. Together they give one attribute byte to each 4 KiB page of the first megabyte.

Below 1 MiB, reads and writes consult different attribute bits, so a page can be readable from RAM while writes to it still reach I/O. Debug reads always follow the read rule. After reset every access goes to I/O until software opens windows.

Top module: `mem_target_router`

## Requirements
- R1: After reset the top-of-memory register reads 0x0010_0000, the configuration register and all eleven memory-type registers read 0, and every access (any address, read or write) is routed to MMIO (`tgt_mmio`=1).
- R2: An address at or above the top-of-memory value is routed to MMIO whatever the page attributes say; this check has priority over every other rule.
- R3: An address below the top-of-memory value and at or above 0x0010_0000 is routed to RAM (`tgt_mmio`=0).
- R4: Below 1 MiB, a read (`req_write`=0) goes to RAM when bit 3 of the page's attribute byte is 1, and to MMIO otherwise.
- R5: Below 1 MiB, a non-debug write goes to RAM when bit 4 of the page's attribute byte is 1, and to MMIO otherwise.
- R6: When `req_debug`=1 the routing uses attribute bit 3 even if `req_write`=1.
- R7: `cacheable` is 1 only for an address below 1 MiB whose attribute byte has a nonzero value in bits 2:0; at or above 1 MiB it is 0.
- R8: Attribute bytes come from the memory-type registers, with byte k held in data bits 8k+7:8k. Index 0x250 covers 0x00000–0x7FFFF in 64 KiB steps. Index 0x258 covers 0x80000–0x9FFFF in 16 KiB steps, and index 0x259 covers 0xA0000–0xBFFFF in 16 KiB steps. Indices 0x268 to 0x26F cover 0xC0000–0xFFFFF in 4 KiB steps, 32 KiB per register.
- R9: Index 0xC001001A holds the top-of-memory bound in its low 32 data bits and reads its upper 32 bits as 0. Index 0xC0010010 stores and returns all 64 bits. Each memory-type index returns what was last written to it.
- R10: Reading an index not listed in R8 or R9 returns 0 with `msr_invalid`=1, and a write to such an index changes no register.
- R11: Routing and read data are combinational; a register write is applied at the clock edge where `msr_we` is sampled high and affects routing from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msr_we | input | 1 | Register write strobe |
| msr_index | input | 32 | Register index for read and write |
| msr_wdata | input | 64 | Register write data |
| msr_rdata | output | 64 | Read data for `msr_index` |
| msr_invalid | output | 1 | `msr_index` names no implemented register |
| req_addr | input | 32 | Physical address of the access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_debug | input | 1 | Debug view: route by the read rule |
| tgt_mmio | output | 1 | 1 = MMIO target, 0 = RAM target |
| cacheable | output | 1 | Page attribute permits caching |

## Verification
The hardest case is a page whose read and write bits disagree, seen through each of the three access flavours. The page must also sit in a memory-type register with a non-trivial step size, so that a wrong byte or register select shows up. The stimulus writes one marked byte into a 64 KiB register, a 16 KiB register and a 4 KiB register. It then probes the first page of each marked range and the page just below it as reads, writes and debug writes. Priority is covered by lowering the top-of-memory bound below 1 MiB over a page that would otherwise go to RAM.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
    localparam int NUM_FIX = 11;
    localparam int FIX_SLOT_W = 4;

    localparam logic [31:0] IDX_TOP_BOUND = 32'hC001_001A;
    localparam logic [31:0] IDX_SYS_CFG   = 32'hC001_0010;
    localparam logic [31:0] IDX_FIX_64K   = 32'h0000_0250;
    localparam logic [31:0] IDX_FIX_16K_A = 32'h0000_0258;
    localparam logic [31:0] IDX_FIX_16K_B = 32'h0000_0259;
    localparam logic [31:0] IDX_FIX_4K_0  = 32'h0000_0268;

    typedef struct packed {
        logic                  hit;
        logic [FIX_SLOT_W-1:0] slot;
    } fix_sel_t;

    // Map a register index onto one of the fixed-range slots.
    function automatic fix_sel_t fix_decode(input logic [31:0] idx);
        fix_sel_t s;
        s.hit  = 1'b0;
        s.slot = '0;
        if (idx == IDX_FIX_64K) begin
            s.hit = 1'b1;  s.slot = 4'd0;
        end else if (idx == IDX_FIX_16K_A) begin
            s.hit = 1'b1;  s.slot = 4'd1;
        end else if (idx == IDX_FIX_16K_B) begin
            s.hit = 1'b1;  s.slot = 4'd2;
        end else if (idx[31:3] == IDX_FIX_4K_0[31:3]) begin
            s.hit = 1'b1;  s.slot = 4'd3 + {1'b0, idx[2:0]};
        end
        return s;
    endfunction
endpackage

// File: rtl/mtr_msr_file.sv
module mtr_msr_file
    import mtr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter logic [ADDR_W-1:0] TOP_RESET = ADDR_W'(32'h0010_0000)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           msr_we,
    input  logic [31:0]                    msr_index,
    input  logic [DATA_W-1:0]              msr_wdata,
    output logic [DATA_W-1:0]              msr_rdata,
    output logic                           msr_invalid,
    output logic [ADDR_W-1:0]              top_bound,
    output logic [DATA_W-1:0]              sys_cfg,
    output logic [NUM_FIX-1:0][DATA_W-1:0] fix_regs
);
    typedef struct packed {
        logic [ADDR_W-1:0]              top;
        logic [DATA_W-1:0]              cfg;
        logic [NUM_FIX-1:0][DATA_W-1:0] fix;
    } regs_t;

    regs_t    regs_d, regs_q;
    fix_sel_t sel;
    logic     hit_top, hit_cfg;

    always_comb begin
        regs_d  = regs_q;
        sel     = fix_decode(msr_index);
        hit_top = (msr_index == IDX_TOP_BOUND);
        hit_cfg = (msr_index == IDX_SYS_CFG);

        msr_invalid = !(hit_top || hit_cfg || sel.hit);
        msr_rdata   = '0;
        if (hit_top) msr_rdata = DATA_W'(regs_q.top);
        if (hit_cfg) msr_rdata = regs_q.cfg;
        if (sel.hit) msr_rdata = regs_q.fix[sel.slot];

        if (msr_we) begin
            if (hit_top) regs_d.top = msr_wdata[ADDR_W-1:0];
            if (hit_cfg) regs_d.cfg = msr_wdata;
            if (sel.hit) regs_d.fix[sel.slot] = msr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.top <= TOP_RESET;
            regs_q.cfg <= '0;
            regs_q.fix <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign top_bound = regs_q.top;
    assign sys_cfg   = regs_q.cfg;
    assign fix_regs  = regs_q.fix;
endmodule

// File: rtl/mtr_page_attr.sv
module mtr_page_attr
    import mtr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ATTR_W = 8
) (
    input  logic [NUM_FIX-1:0][DATA_W-1:0] fix_regs,
    input  logic [7:0]                     page,
    output logic [ATTR_W-1:0]              attr
);
    localparam int FIELDS = DATA_W / ATTR_W;

    logic [ATTR_W-1:0]     field_of [NUM_FIX][FIELDS];
    logic [FIX_SLOT_W-1:0] reg_sel;
    logic [2:0]            byte_sel;

    for (genvar r = 0; r < NUM_FIX; r++) begin : g_reg
        for (genvar b = 0; b < FIELDS; b++) begin : g_field
            assign field_of[r][b] = fix_regs[r][ATTR_W*b +: ATTR_W];
        end
    end

    // Page 0..127: 64 KiB fields; 128..191: 16 KiB fields; 192..255: 4 KiB fields.
    always_comb begin
        if (!page[7]) begin
            reg_sel  = 4'd0;
            byte_sel = page[6:4];
        end else if (!page[6]) begin
            reg_sel  = 4'd1 + {3'b000, page[5]};
            byte_sel = page[4:2];
        end else begin
            reg_sel  = 4'd3 + {1'b0, page[5:3]};
            byte_sel = page[2:0];
        end
        attr = field_of[reg_sel][byte_sel];
    end
endmodule

// File: rtl/mtr_route.sv
module mtr_route #(
    parameter int ADDR_W    = 32,
    parameter int ATTR_W    = 8,
    parameter int LOW_LIMIT = 32'h0010_0000
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_debug,
    input  logic [ADDR_W-1:0] top_bound,
    input  logic [ATTR_W-1:0] attr,
    output logic              tgt_mmio,
    output logic              cacheable
);
    localparam int RD_EN_BIT = 3;
    localparam int WR_EN_BIT = 4;
    localparam logic [ADDR_W-1:0] LOW_BOUND = ADDR_W'(LOW_LIMIT);

    logic below_low;
    logic use_write_rule;
    logic unused_attr_hi;

    assign unused_attr_hi = ^attr[ATTR_W-1:WR_EN_BIT+1];

    always_comb begin
        below_low      = (req_addr < LOW_BOUND);
        use_write_rule = req_write && !req_debug;
        if (req_addr >= top_bound)
            tgt_mmio = 1'b1;
        else if (!below_low)
            tgt_mmio = 1'b0;
        else if (use_write_rule)
            tgt_mmio = !attr[WR_EN_BIT];
        else
            tgt_mmio = !attr[RD_EN_BIT];
        cacheable = below_low && (attr[2:0] != 3'b000);
    end
endmodule

// File: rtl/mem_target_router.sv
module mem_target_router
    import mtr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int LOW_LIMIT  = 32'h0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msr_we,
    input  logic [31:0]       msr_index,
    input  logic [DATA_W-1:0] msr_wdata,
    output logic [DATA_W-1:0] msr_rdata,
    output logic              msr_invalid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_debug,
    output logic              tgt_mmio,
    output logic              cacheable
);
    localparam int ATTR_W = 8;
    localparam int PAGE_W = $clog2(LOW_LIMIT >> PAGE_SHIFT);

    logic [ADDR_W-1:0]              top_bound;
    logic [DATA_W-1:0]              sys_cfg;
    logic [NUM_FIX-1:0][DATA_W-1:0] fix_regs;
    logic [ATTR_W-1:0]              page_attr;

    mtr_msr_file #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .TOP_RESET(ADDR_W'(LOW_LIMIT))
    ) u_msr (
        .clk        (clk),
        .rst_n      (rst_n),
        .msr_we     (msr_we),
        .msr_index  (msr_index),
        .msr_wdata  (msr_wdata),
        .msr_rdata  (msr_rdata),
        .msr_invalid(msr_invalid),
        .top_bound  (top_bound),
        .sys_cfg    (sys_cfg),
        .fix_regs   (fix_regs)
    );

    mtr_page_attr #(
        .DATA_W(DATA_W),
        .ATTR_W(ATTR_W)
    ) u_attr (
        .fix_regs(fix_regs),
        .page    (req_addr[PAGE_SHIFT +: PAGE_W]),
        .attr    (page_attr)
    );

    mtr_route #(
        .ADDR_W   (ADDR_W),
        .ATTR_W   (ATTR_W),
        .LOW_LIMIT(LOW_LIMIT)
    ) u_route (
        .req_addr (req_addr),
        .req_write(req_write),
        .req_debug(req_debug),
        .top_bound(top_bound),
        .attr     (page_attr),
        .tgt_mmio (tgt_mmio),
        .cacheable(cacheable)
    );
endmodule

// File: rtl/mtr_router_checker.sv
module mtr_router_checker #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int LOW_LIMIT = 32'h0010_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msr_we,
    input logic              msr_invalid,
    input logic [DATA_W-1:0] msr_rdata,
    input logic [ADDR_W-1:0] req_addr,
    input logic              tgt_mmio,
    input logic              cacheable,
    input logic [ADDR_W-1:0] top_bound,
    input logic [DATA_W-1:0] sys_cfg
);
    localparam logic [ADDR_W-1:0] LOW_BOUND = ADDR_W'(LOW_LIMIT);

    p_reset_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (top_bound == LOW_BOUND) && (sys_cfg == '0));

    p_top_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr >= top_bound) |-> tgt_mmio);

    p_high_ram_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr >= LOW_BOUND && req_addr < top_bound) |-> !tgt_mmio);

    p_high_uncached_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr >= LOW_BOUND) |-> !cacheable);

    p_invalid_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msr_invalid |-> (msr_rdata == '0));

    p_bad_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_we && msr_invalid) |=> $stable(top_bound) && $stable(sys_cfg));

    p_hold_without_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_we |=> $stable(top_bound) && $stable(sys_cfg));
endmodule

bind mem_target_router mtr_router_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LOW_LIMIT(LOW_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msr_we     (msr_we),
    .msr_invalid(msr_invalid),
    .msr_rdata  (msr_rdata),
    .req_addr   (req_addr),
    .tgt_mmio   (tgt_mmio),
    .cacheable  (cacheable),
    .top_bound  (top_bound),
    .sys_cfg    (sys_cfg)
);

// File: tb/test_mem_target_router.sv
module test_mem_target_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msr_we = 1'b0;
    logic [31:0] msr_index = '0;
    logic [63:0] msr_wdata = '0;
    logic [63:0] msr_rdata;
    logic        msr_invalid;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_debug = 1'b0;
    logic        tgt_mmio;
    logic        cacheable;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mem_target_router i_mem_target_router (
        .clk(clk), .rst_n(rst_n),
        .msr_we(msr_we), .msr_index(msr_index), .msr_wdata(msr_wdata),
        .msr_rdata(msr_rdata), .msr_invalid(msr_invalid),
        .req_addr(req_addr), .req_write(req_write), .req_debug(req_debug),
        .tgt_mmio(tgt_mmio), .cacheable(cacheable)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic msr_write(input logic [31:0] idx, input logic [63:0] data);
        @(negedge clk);
        msr_index = idx;
        msr_wdata = data;
        msr_we    = 1'b1;
        @(posedge clk);
        #1;
        msr_we = 1'b0;
    endtask

    task automatic msr_read(input logic [31:0] idx, output logic [63:0] data, output logic bad);
        @(negedge clk);
        msr_index = idx;
        #1;
        data = msr_rdata;
        bad  = msr_invalid;
    endtask

    // Returns {tgt_mmio, cacheable}.
    task automatic probe(input logic [31:0] addr, input logic wr, input logic dbg,
                         output logic [1:0] res);
        @(negedge clk);
        req_addr  = addr;
        req_write = wr;
        req_debug = dbg;
        #1;
        res = {tgt_mmio, cacheable};
    endtask

    task automatic t_reset_state;
        logic [63:0] d; logic b; logic [1:0] r;
        msr_read(32'hC001_001A, d, b); check("R1 top after reset", d, 64'h0010_0000);
        msr_read(32'hC001_0010, d, b); check("R1 cfg after reset", d, 64'h0);
        msr_read(32'h0000_0259, d, b); check("R1 fixed reg after reset", d, 64'h0);
        probe(32'h0000_0000, 1'b0, 1'b0, r); check("R1 page 0 read -> MMIO", r, 2'b10);
        probe(32'h000C_0000, 1'b1, 1'b0, r); check("R1 low write -> MMIO", r, 2'b10);
        probe(32'h0020_0000, 1'b0, 1'b0, r); check("R1 high read -> MMIO", r, 2'b10);
    endtask

    task automatic t_register_readback;
        logic [63:0] d; logic b;
        msr_write(32'hC001_0010, 64'hA5A5_0001_C3C3_0F0F);
        msr_read(32'hC001_0010, d, b); check("R9 cfg 64-bit readback", d, 64'hA5A5_0001_C3C3_0F0F);
        check("R9 cfg index valid", {63'b0, b}, 64'h0);
        msr_write(32'hC001_001A, 64'hFFFF_FFFF_4000_0000);
        msr_read(32'hC001_001A, d, b); check("R9 top keeps low 32 bits", d, 64'h4000_0000);
    endtask

    task automatic t_high_region;
        logic [1:0] r;
        probe(32'h0020_0000, 1'b0, 1'b0, r); check("R3 above 1MiB below top -> RAM", r, 2'b00);
        probe(32'h3FFF_FFFC, 1'b1, 1'b0, r); check("R3 just below top -> RAM", r, 2'b00);
        probe(32'h4000_0000, 1'b0, 1'b0, r); check("R2 at top -> MMIO", r, 2'b10);
        probe(32'hFFFF_F000, 1'b1, 1'b0, r); check("R2 far above top -> MMIO", r, 2'b10);
    endtask

    task automatic t_fixed_64k;
        logic [1:0] r; logic [63:0] d; logic b;
        // field 2 (0x20000-0x2FFFF) = read+cache; field 5 (0x50000-0x5FFFF) = write only
        msr_write(32'h0000_0250, 64'h0000_1000_000E_0000);
        msr_read(32'h0000_0250, d, b); check("R9 fixed reg readback", d, 64'h0000_1000_000E_0000);
        probe(32'h0002_0000, 1'b0, 1'b0, r); check("R4 read bit set -> RAM, R7 cacheable", r, 2'b01);
        probe(32'h0002_FFFC, 1'b1, 1'b0, r); check("R5 write bit clear -> MMIO", r, 2'b11);
        probe(32'h0001_FFFC, 1'b0, 1'b0, r); check("R8 page below 64K field -> MMIO", r, 2'b10);
        probe(32'h0005_0000, 1'b1, 1'b0, r); check("R5 write bit set -> RAM", r, 2'b00);
        probe(32'h0005_0000, 1'b0, 1'b0, r); check("R4 read bit clear -> MMIO", r, 2'b10);
        probe(32'h0005_0000, 1'b1, 1'b1, r); check("R6 debug write uses read bit -> MMIO", r, 2'b10);
        probe(32'h0002_0000, 1'b1, 1'b1, r); check("R6 debug write uses read bit -> RAM", r, 2'b01);
    endtask

    task automatic t_fixed_16k;
        logic [1:0] r;
        // index 0x259 field 3 -> 0xAC000-0xAFFFF
        msr_write(32'h0000_0259, 64'h0000_0000_1800_0000);
        probe(32'h000A_C000, 1'b0, 1'b0, r); check("R8 16K field start read -> RAM", r, 2'b00);
        probe(32'h000A_FFFC, 1'b1, 1'b0, r); check("R8 16K field end write -> RAM", r, 2'b00);
        probe(32'h000A_BFFC, 1'b0, 1'b0, r); check("R8 16K previous field -> MMIO", r, 2'b10);
        probe(32'h0008_C000, 1'b0, 1'b0, r); check("R8 same field in 0x258 -> MMIO", r, 2'b10);
    endtask

    task automatic t_fixed_4k;
        logic [1:0] r;
        // index 0x26F field 7 -> 0xFF000; index 0x268 field 0 -> 0xC0000
        msr_write(32'h0000_026F, 64'h0800_0000_0000_0000);
        msr_write(32'h0000_0268, 64'h0000_0000_0000_001F);
        probe(32'h000F_F000, 1'b0, 1'b0, r); check("R8 4K last page read -> RAM", r, 2'b00);
        probe(32'h000F_E000, 1'b0, 1'b0, r); check("R8 4K neighbour page -> MMIO", r, 2'b10);
        probe(32'h000C_0000, 1'b1, 1'b0, r); check("R5 4K first page write -> RAM", r, 2'b01);
        probe(32'h000C_1000, 1'b1, 1'b0, r); check("R8 4K second page -> MMIO", r, 2'b10);
    endtask

    task automatic t_invalid_index;
        logic [63:0] d; logic b; logic [1:0] r;
        msr_read(32'h0000_0123, d, b);
        check("R10 unknown index data", d, 64'h0);
        check("R10 unknown index flag", {63'b0, b}, 64'h1);
        msr_write(32'h0000_0123, 64'hFFFF_FFFF_FFFF_FFFF);
        msr_write(32'h0000_0260, 64'hFFFF_FFFF_FFFF_FFFF);
        msr_read(32'hC001_001A, d, b); check("R10 top unchanged", d, 64'h4000_0000);
        msr_read(32'hC001_0010, d, b); check("R10 cfg unchanged", d, 64'hA5A5_0001_C3C3_0F0F);
        probe(32'h0009_0000, 1'b0, 1'b0, r); check("R10 attributes unchanged", r, 2'b10);
    endtask

    task automatic t_write_timing_and_priority;
        logic [1:0] r;
        @(negedge clk);
        req_addr = 32'h0002_0000; req_write = 1'b0; req_debug = 1'b0;
        msr_index = 32'hC001_001A; msr_wdata = 64'h0000_0000_0001_0000; msr_we = 1'b1;
        #1;
        check("R11 old bound before edge", {62'b0, tgt_mmio, cacheable}, 64'h1);
        @(posedge clk);
        #1;
        msr_we = 1'b0;
        check("R11 new bound after edge", {62'b0, tgt_mmio, cacheable}, 64'h3);
        probe(32'h0000_FFFC, 1'b0, 1'b0, r); check("R2 below low bound uses attribute", r, 2'b10);
        probe(32'h0020_0000, 1'b0, 1'b0, r); check("R2 high address above small top -> MMIO", r, 2'b10);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_register_readback();
        t_high_region();
        t_fixed_64k();
        t_fixed_16k();
        t_fixed_4k();
        t_invalid_index();
        t_write_timing_and_priority();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule